// File: doc/BRIEF.md
# Differential Clock Fanout Stop and Power-Down Control

This block is the digital control of an eight-pair differential clock fanout. It turns a reference clock into one running output phase and, for every pair, gives a true value, a complement value and two drive flags. A drive flag at 0 stands for a tri-stated pin, and an undriven pin reads 0. The clock `clk` runs at twice the source clock rate. With `full_rate` at 1 the output phase toggles on every `clk` cycle, which is the source frequency. With `full_rate` at 0 it toggles on every second cycle, which is half the source frequency.

Two asynchronous requests, stop and power-down, go through a synchronizer. Each is then accepted only after it shows the same level at two consecutive rising edges of the complement output. Accepted requests park pairs on a clean edge and release them on a clean edge. Pairs marked stoppable obey stop, free-running pairs ignore it, and power-down acts on every pair and takes priority over stop. Each pair is gated by its own enable pin and by a register enable bit. The sense of the enable pins and of the stop and power-down inputs follows a polarity input, which is captured once when reset is released.

Top module: `cb_fanout_ctl`

## Requirements
- R1: While `rst_n` is low, every pair whose enable pin and register enable are both active drives true 0 and complement 1, with both drive flags at 1.
- R2: With `full_rate`=1 the true output of a running pair toggles on every `clk` cycle. With `full_rate`=0 it toggles on every second cycle.
- R3: A running pair has both drive flags at 1 and complement equal to the inverse of true, and all running pairs show the same true value in every cycle.
- R4: A pair is driven only when its enable pin is active and its `cfg_en` bit is 1. Otherwise all four of its outputs are 0, because an undriven pin reads 0.
- R5: `pol_sel` is captured on the first clock after reset is released, and later changes have no effect. At 0 the enable pins are active high and `stop_in` and `pd_in` are active low. At 1 all three senses are inverted.
- R6: A stop or power-down level is accepted only when it is seen at the same level on two consecutive rising edges of the complement (true falling). A one-cycle pulse on `stop_in` has no effect.
- R7: When stop is accepted, each pair with its `cfg_stoppable` bit at 1 halts after its next rising true transition. Pairs with the bit at 0 keep toggling.
- R8: A stop-parked pair with `stop_tri`=0 drives true 1 with drive flags true=1 and complement=0. With `stop_tri`=1 all four of its outputs are 0.
- R9: After stop is released, all stop-parked pairs resume in the same cycle, between 2 and 6 output periods later. The first resumed sample shows true 1, so no short pulse appears.
- R10: When power-down is accepted, every enabled pair parks at the next falling edge of the complement. With `pd_tri`=0 the pair drives true 1 with drive flags true=1 and complement=0. With `pd_tri`=1 all four of its outputs are 0.
- R11: While power-down is parked, its drive state applies to stoppable and free-running pairs alike, and it overrides any stop state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock at twice the source rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pol_sel | input | 1 | Polarity select, captured after reset |
| full_rate | input | 1 | 1 = source rate, 0 = half rate |
| stop_in | input | 1 | Asynchronous stop request, sense set by polarity |
| pd_in | input | 1 | Asynchronous power-down request, sense set by polarity |
| oe_pin | input | NUM_PAIRS | Per-pair enable pins, sense set by polarity |
| cfg_en | input | NUM_PAIRS | Per-pair register enable, 1 = enabled |
| cfg_stoppable | input | NUM_PAIRS | Per-pair: 1 = obeys stop, 0 = free-running |
| stop_tri | input | 1 | Stop park mode: 0 = true high driven, 1 = undriven |
| pd_tri | input | 1 | Power-down park mode: 0 = true high driven, 1 = undriven |
| clk_true | output | NUM_PAIRS | True output values |
| clk_comp | output | NUM_PAIRS | Complement output values |
| drv_true | output | NUM_PAIRS | True output drive flags |
| drv_comp | output | NUM_PAIRS | Complement output drive flags |

## Verification
Enable, rate and park-mode changes are due within one or two cycles, because they pass at most one register. The bench therefore samples these on the negative edge a few cycles after the change. Stop and power-down requests pass two synchronizer stages and two complement rising edges, and then wait for a complement falling edge, so they settle within seven cycles at full rate. The bench waits twenty cycles before judging a parked state and confirms that the state holds over a window of cycles. Resume latency is measured by polling every cycle from the release of stop and is compared against the 2 to 6 period window.

// File: rtl/cb_pkg.sv
package cb_pkg;
  typedef enum logic [1:0] {
    DRV_RUN       = 2'd0,
    DRV_HIGH_ONLY = 2'd1,
    DRV_NONE      = 2'd2
  } pair_mode_e;
endpackage

// File: rtl/cb_phase_gen.sv
module cb_phase_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic full_rate,
  output logic phase,
  output logic comp_rise,
  output logic comp_fall
);
  logic div_q, div_d;
  logic ph_q, ph_d;
  logic tick;

  assign tick = full_rate | div_q;

  always_comb begin
    div_d = ~div_q;
    ph_d  = ph_q;
    if (tick) ph_d = ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= 1'b0;
      ph_q  <= 1'b0;
    end else begin
      div_q <= div_d;
      ph_q  <= ph_d;
    end
  end

  assign phase     = ph_q;
  assign comp_rise = tick & ph_q;
  assign comp_fall = tick & ~ph_q;
endmodule

// File: rtl/cb_req_filter.sv
module cb_req_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async,
  input  logic sample_en,
  output logic accepted
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic level;
  logic last_q, last_d;
  logic acc_q, acc_d;

  assign level = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], req_async};
    last_d = last_q;
    acc_d  = acc_q;
    if (sample_en) begin
      last_d = level;
      if (level == last_q) acc_d = level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
      acc_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
      acc_q  <= acc_d;
    end
  end

  assign accepted = acc_q;
endmodule

// File: rtl/cb_pair_drv.sv
module cb_pair_drv
  import cb_pkg::*;
(
  input  logic phase,
  input  logic enable,
  input  logic stoppable,
  input  logic stop_park,
  input  logic pd_park,
  input  logic stop_tri,
  input  logic pd_tri,
  output logic o_true,
  output logic o_comp,
  output logic o_drv_t,
  output logic o_drv_c
);
  pair_mode_e mode;

  always_comb begin
    if (!enable)                      mode = DRV_NONE;
    else if (pd_park)                 mode = pd_tri ? DRV_NONE : DRV_HIGH_ONLY;
    else if (stop_park && stoppable)  mode = stop_tri ? DRV_NONE : DRV_HIGH_ONLY;
    else                              mode = DRV_RUN;
  end

  always_comb begin
    o_true  = 1'b0;
    o_comp  = 1'b0;
    o_drv_t = 1'b0;
    o_drv_c = 1'b0;
    case (mode)
      DRV_RUN: begin
        o_true  = phase;
        o_comp  = ~phase;
        o_drv_t = 1'b1;
        o_drv_c = 1'b1;
      end
      DRV_HIGH_ONLY: begin
        o_true  = 1'b1;
        o_drv_t = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cb_fanout_ctl.sv
module cb_fanout_ctl #(
  parameter int NUM_PAIRS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pol_sel,
  input  logic                 full_rate,
  input  logic                 stop_in,
  input  logic                 pd_in,
  input  logic [NUM_PAIRS-1:0] oe_pin,
  input  logic [NUM_PAIRS-1:0] cfg_en,
  input  logic [NUM_PAIRS-1:0] cfg_stoppable,
  input  logic                 stop_tri,
  input  logic                 pd_tri,
  output logic [NUM_PAIRS-1:0] clk_true,
  output logic [NUM_PAIRS-1:0] clk_comp,
  output logic [NUM_PAIRS-1:0] drv_true,
  output logic [NUM_PAIRS-1:0] drv_comp
);
  // Polarity capture: taken once on the first clock after reset
  logic pol_q, pol_d, lock_q, lock_d;

  always_comb begin
    pol_d  = lock_q ? pol_q : pol_sel;
    lock_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      pol_q  <= pol_d;
      lock_q <= lock_d;
    end
  end

  // Active-high request decode
  logic stop_req, pd_req;
  logic [NUM_PAIRS-1:0] oe_act;
  assign stop_req = ~(stop_in ^ pol_q);
  assign pd_req   = ~(pd_in ^ pol_q);
  assign oe_act   = oe_pin ^ {NUM_PAIRS{pol_q}};

  logic phase, comp_rise, comp_fall;

  cb_phase_gen u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .full_rate (full_rate),
    .phase     (phase),
    .comp_rise (comp_rise),
    .comp_fall (comp_fall)
  );

  logic stop_acc, pd_acc;

  cb_req_filter #(.SYNC_STAGES(SYNC_STAGES)) u_stop_flt (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_async (stop_req),
    .sample_en (comp_rise),
    .accepted  (stop_acc)
  );

  cb_req_filter #(.SYNC_STAGES(SYNC_STAGES)) u_pd_flt (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_async (pd_req),
    .sample_en (comp_rise),
    .accepted  (pd_acc)
  );

  // Park state changes only where true rises, so entry and exit are clean
  logic stop_park_q, stop_park_d, pd_park_q, pd_park_d;

  always_comb begin
    stop_park_d = stop_park_q;
    pd_park_d   = pd_park_q;
    if (comp_fall) begin
      stop_park_d = stop_acc;
      pd_park_d   = pd_acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_park_q <= 1'b0;
      pd_park_q   <= 1'b0;
    end else begin
      stop_park_q <= stop_park_d;
      pd_park_q   <= pd_park_d;
    end
  end

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    cb_pair_drv u_drv (
      .phase     (phase),
      .enable    (oe_act[g] & cfg_en[g]),
      .stoppable (cfg_stoppable[g]),
      .stop_park (stop_park_q),
      .pd_park   (pd_park_q),
      .stop_tri  (stop_tri),
      .pd_tri    (pd_tri),
      .o_true    (clk_true[g]),
      .o_comp    (clk_comp[g]),
      .o_drv_t   (drv_true[g]),
      .o_drv_c   (drv_comp[g])
    );
  end
endmodule

// File: rtl/cb_fanout_chk.sv
module cb_fanout_chk #(
  parameter int NUM_PAIRS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_PAIRS-1:0] cfg_en,
  input logic [NUM_PAIRS-1:0] clk_true,
  input logic [NUM_PAIRS-1:0] clk_comp,
  input logic [NUM_PAIRS-1:0] drv_true,
  input logic [NUM_PAIRS-1:0] drv_comp
);
  logic [NUM_PAIRS-1:0] run_mask;
  assign run_mask = drv_true & drv_comp;

  AST_UNDRIVEN_READS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((clk_true & ~drv_true) | (clk_comp & ~drv_comp)) == '0); // R4

  AST_RUN_COMP_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mask & ~(clk_true ^ clk_comp)) == '0); // R3

  AST_RUN_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((clk_true & run_mask) == '0) || ((clk_true & run_mask) == run_mask)); // R3

  AST_PARK_TRUE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_true & ~drv_comp & ~clk_true) == '0); // R8

  AST_DISABLED_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((drv_true | drv_comp) & ~cfg_en) == '0); // R4
endmodule

bind cb_fanout_ctl cb_fanout_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_en   (cfg_en),
  .clk_true (clk_true),
  .clk_comp (clk_comp),
  .drv_true (drv_true),
  .drv_comp (drv_comp)
);

// File: tb/tb_cb_fanout_ctl.sv
module tb_cb_fanout_ctl;
  localparam int N = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n, pol_sel, full_rate, stop_in, pd_in, stop_tri, pd_tri;
  logic [N-1:0] oe_pin, cfg_en, cfg_stoppable;
  logic [N-1:0] clk_true, clk_comp, drv_true, drv_comp;

  cb_fanout_ctl #(.NUM_PAIRS(N)) dut (
    .clk(clk), .rst_n(rst_n), .pol_sel(pol_sel), .full_rate(full_rate),
    .stop_in(stop_in), .pd_in(pd_in), .oe_pin(oe_pin), .cfg_en(cfg_en),
    .cfg_stoppable(cfg_stoppable), .stop_tri(stop_tri), .pd_tri(pd_tri),
    .clk_true(clk_true), .clk_comp(clk_comp), .drv_true(drv_true), .drv_comp(drv_comp)
  );

  int errors = 0;
  int checks = 0;
  int tog [N];
  logic [N-1:0] steady;
  int mismatch;
  int cyc = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic observe(input int n);
    logic [N-1:0] t0, c0, dt0, dc0, pt, rm;
    @(negedge clk);
    t0 = clk_true; c0 = clk_comp; dt0 = drv_true; dc0 = drv_comp; pt = clk_true;
    steady = '1; mismatch = 0;
    for (int i = 0; i < N; i++) tog[i] = 0;
    repeat (n) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) if (clk_true[i] != pt[i]) tog[i]++;
      steady &= ~((clk_true ^ t0) | (clk_comp ^ c0) | (drv_true ^ dt0) | (drv_comp ^ dc0));
      rm = drv_true & drv_comp;
      if ((rm & ~(clk_true ^ clk_comp)) != '0) mismatch++;
      if (((clk_true & rm) != '0) && ((clk_true & rm) != rm)) mismatch++;
      pt = clk_true;
    end
  endtask

  task automatic do_reset(input logic pol);
    rst_n = 1'b0; pol_sel = pol; stop_in = ~pol; pd_in = ~pol;
    oe_pin = {N{~pol}}; cfg_en = '1; cfg_stoppable = '0;
    stop_tri = 1'b0; pd_tri = 1'b0; full_rate = 1'b1;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pol_sel = 1'b0; stop_in = 1'b1; pd_in = 1'b1;
    oe_pin = '1; cfg_en = '1; cfg_stoppable = '0;
    stop_tri = 1'b0; pd_tri = 1'b0; full_rate = 1'b1;
    wait_cyc(3);
    chk(clk_true == '0, "R1", "reset true", clk_true, 0);
    chk(clk_comp == '1, "R1", "reset comp", clk_comp, 8'hFF);
    chk((drv_true & drv_comp) == '1, "R1", "reset drive", drv_true & drv_comp, 8'hFF);
    rst_n = 1'b1;
    wait_cyc(4);
  endtask

  task automatic t_rate();
    full_rate = 1'b1; wait_cyc(4);
    observe(16);
    chk(tog[0] == 16, "R2", "full rate toggles", tog[0], 16);
    chk(tog[7] == 16, "R2", "full rate toggles pair7", tog[7], 16);
    chk(mismatch == 0, "R3", "run comp and phase", mismatch, 0);
    full_rate = 1'b0; wait_cyc(4);
    observe(16);
    chk(tog[3] == 8, "R2", "half rate toggles", tog[3], 8);
    chk(mismatch == 0, "R3", "run comp and phase half", mismatch, 0);
    full_rate = 1'b1; wait_cyc(4);
  endtask

  task automatic t_enable();
    cfg_en = 8'h0F; oe_pin = 8'hFB; wait_cyc(2);
    observe(8);
    chk(((drv_true | drv_comp | clk_true | clk_comp) & 8'hF4) == '0, "R4", "disabled pairs zero",
        (drv_true | drv_comp | clk_true | clk_comp) & 8'hF4, 0);
    chk((steady & 8'hF4) == 8'hF4, "R4", "disabled steady", steady, 8'hF4);
    chk(tog[0] == 8 && tog[3] == 8, "R4", "enabled pairs run", tog[3], 8);
    cfg_en = '1; oe_pin = '1; wait_cyc(2);
  endtask

  task automatic t_glitch();
    cfg_stoppable = '1; stop_tri = 1'b1;
    stop_in = 1'b0; wait_cyc(1); stop_in = 1'b1;
    observe(20);
    chk(tog[0] == 20, "R6", "one-cycle stop ignored", tog[0], 20);
    chk(drv_true == '1, "R6", "still driven", drv_true, 8'hFF);
    cfg_stoppable = '0; stop_tri = 1'b0;
  endtask

  task automatic t_stop();
    int k;
    cfg_stoppable = 8'h0F; stop_tri = 1'b1; stop_in = 1'b0;
    wait_cyc(20);
    observe(12);
    chk(((drv_true | drv_comp | clk_true | clk_comp) & 8'h0F) == '0, "R8", "stop tri zero",
        (drv_true | drv_comp | clk_true | clk_comp) & 8'h0F, 0);
    chk((steady & 8'h0F) == 8'h0F, "R7", "stoppable halted", steady, 8'h0F);
    chk(tog[4] == 12 && tog[7] == 12, "R7", "free-run continues", tog[4], 12);
    stop_tri = 1'b0; wait_cyc(2);
    observe(8);
    chk((clk_true & 8'h0F) == 8'h0F && (drv_true & 8'h0F) == 8'h0F, "R8", "stop high driven",
        {clk_true, drv_true}, 16'h0F0F);
    chk((drv_comp & 8'h0F) == '0 && (clk_comp & 8'h0F) == '0, "R8", "stop comp undriven",
        {clk_comp, drv_comp}, 0);
    chk((steady & 8'h0F) == 8'h0F, "R8", "stop high steady", steady, 8'h0F);
    stop_in = 1'b1;
    k = 0;
    for (int j = 1; j <= 20; j++) begin
      @(negedge clk);
      k = j;
      if ((drv_comp & 8'h0F) != '0) break;
    end
    chk(k >= 4 && k <= 12, "R9", "resume latency cycles", k, 12);
    chk((drv_comp & 8'h0F) == 8'h0F, "R9", "resume together", drv_comp, 8'hFF);
    chk(clk_true[0] == 1'b1, "R9", "first resumed true high", clk_true[0], 1);
    cfg_stoppable = '0; wait_cyc(4);
  endtask

  task automatic t_pd();
    cfg_stoppable = 8'h0F; stop_tri = 1'b1; stop_in = 1'b0;
    wait_cyc(20);
    pd_in = 1'b0;
    wait_cyc(20);
    observe(8);
    chk(clk_true == '1 && drv_true == '1, "R10", "pd true high driven", {clk_true, drv_true}, 16'hFFFF);
    chk(clk_comp == '0 && drv_comp == '0, "R10", "pd comp undriven", {clk_comp, drv_comp}, 0);
    chk(steady == '1, "R11", "pd overrides stop and free-run", steady, 8'hFF);
    pd_tri = 1'b1; wait_cyc(2);
    chk((drv_true | drv_comp | clk_true | clk_comp) == '0, "R10", "pd tri zero",
        drv_true | drv_comp | clk_true | clk_comp, 0);
    pd_in = 1'b1; stop_in = 1'b1; pd_tri = 1'b0; stop_tri = 1'b0;
    wait_cyc(30);
    observe(8);
    chk(tog[0] == 8 && tog[5] == 8, "R10", "pd released runs", tog[0], 8);
    cfg_stoppable = '0;
  endtask

  task automatic t_pol();
    do_reset(1'b1);
    observe(8);
    chk(tog[0] == 8 && drv_true == '1, "R5", "low oe enables at pol 1", drv_true, 8'hFF);
    oe_pin = 8'h04; wait_cyc(2);
    chk(drv_true == 8'hFB, "R5", "high oe disables at pol 1", drv_true, 8'hFB);
    pol_sel = 1'b0; wait_cyc(4);
    chk(drv_true == 8'hFB, "R5", "pol change ignored", drv_true, 8'hFB);
    cfg_stoppable = '1; stop_tri = 1'b1; stop_in = 1'b1;
    wait_cyc(20);
    chk((drv_true | clk_true) == '0, "R5", "high stop active at pol 1", drv_true | clk_true, 0);
    stop_in = 1'b0; wait_cyc(20);
    chk(drv_true == 8'hFB, "R5", "low stop inactive at pol 1", drv_true, 8'hFB);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_rate();
    t_enable();
    t_glitch();
    t_stop();
    t_pd();
    t_pol();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule